// File: doc/BRIEF.md
# Converter Result and Register Bus Port

This block is the converter-side end of a 16-bit parallel bus that is driven by an active-low chip select and a combined read/write line. It keeps the most recent 24-bit conversion result and its five condition flags in an output register. Each time a result is loaded, it drops a ready line low for one cycle. A host collects a result with two consecutive reads. The first read returns the upper sixteen result bits. The second read returns the lower eight result bits together with a status byte.

Register writes take two bus cycles. The first write carries a register address and the second write carries the data for that register. Any read clears a pending address. Register 0 is the control register: setting its top bit turns the next read into a readback of the register named by its low address bits. Register 1 holds a group-delay count. For that many results after any register write, the data-valid status bit stays clear. The bus lines are asynchronous to the block. They are brought into the interface clock domain through two-flop synchronisers, and an access is recognised on the falling edge of the synchronised chip select. The block drives an output word with a separate enable for the pad.

Top module: `adc_bus_port`

## Requirements
- R1: After reset `d_oe` is 0 and `rdy_n` is 1. The stored result, its flags, the data-valid bit, the pending address and the readback request are all clear, and the group-delay register holds `GD_INIT` (default 0).
- R2: When `res_valid` is high at a clock edge, the result is loaded and `rdy_n` goes low for that one following cycle. Otherwise `rdy_n` is high.
- R3: A read is an access whose synchronised `rw_n` is low when the synchronised `cs_n` falls. The first read of a result returns `res_data[23:8]`.
- R4: The next read returns `{res[7:0], dv, stat[4:0], 2'b00}`. Here `dv` is in bit 7 and `stat_in[4:0]` sits in bits 6..2, as captured with the result. Bits 1..0 are zero. After this read, the next read is a first read again.
- R5: `d_oe` is high only for a read. It goes high at most three clock edges after `cs_n` falls and low at most three edges after `cs_n` rises. A write never raises `d_oe`.
- R6: A write is an access with `rw_n` high. The first write latches `d_in[1:0]` as the address, and the following write stores `d_in` into that register.
- R7: A read that falls between an address write and its data write drops the pending address, so the next write is taken as an address.
- R8: A data write to register 0 with bit 15 set makes the next read return register `ctrl[1:0]` instead of result data. That read does not advance the result word sequence, and the request is then cleared.
- R9: If a result is loaded after the first word of a sequence has been read, the second read returns the new result's low bits with `dv` = 0.
- R10: Every data write reloads a counter from register 1. While that counter is non-zero, each loaded result gets `dv` = 0 and decrements it. Results loaded with the counter at zero get `dv` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rw_n | input | 1 | Read (low) / write (high), asynchronous |
| d_in | input | 16 | Bus value seen by the block during writes |
| d_out | output | 16 | Word driven during reads |
| d_oe | output | 1 | Bus drive enable; low means high impedance |
| res_valid | input | 1 | Strobe loading a new result |
| res_data | input | 24 | Conversion result |
| stat_in | input | 5 | Flags {overrange, user filter, low power, filter ok, download ok} |
| rdy_n | output | 1 | Active-low ready pulse |

## Verification
Most faults show up on the first following read. A word-phase bit that is out of step makes upper and lower halves swap. A stale pending address sends data to the wrong register, and the bench sees that on the next readback. A wrong group-delay count or a missed overwrite flag shows only in bit 7 of a second word, possibly several results later. For that reason the bench mixes random loads, reads and writes with small delay values, and compares every read word against its own model.

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
  parameter int DATA_W  = 16,
  parameter int RES_W   = 24,
  parameter int NREG    = 4,
  parameter int GD_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw_n,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic [4:0]        stat_in,
  output logic              rdy_n
);
  localparam int LSB_W   = RES_W - DATA_W;
  localparam int PAD_W   = DATA_W - LSB_W - 6;
  localparam int ADDR_W  = $clog2(NREG);
  localparam int CTRL_A  = 0;
  localparam int GD_A    = 1;

  logic [1:0] cs_sy, rw_sy;
  logic       cs_d;
  logic       cs_s, rw_s, sel_fall, rd_go, wr_go, wr_data;

  assign cs_s     = cs_sy[1];
  assign rw_s     = rw_sy[1];
  assign sel_fall = cs_d & ~cs_s;
  assign rd_go    = sel_fall & ~rw_s;
  assign wr_go    = sel_fall & rw_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= '1;
      rw_sy <= '1;
      cs_d  <= 1'b1;
    end else begin
      cs_sy <= {cs_sy[0], cs_n};
      rw_sy <= {rw_sy[0], rw_n};
      cs_d  <= cs_s;
    end

  logic [DATA_W-1:0] regs [NREG];
  logic [RES_W-1:0]  res_q;
  logic [4:0]        st_q;
  logic [DATA_W-1:0] gd_cnt, d_q, gd_next, lo_word, rd_word;
  logic [ADDR_W-1:0] addr_q;
  logic dv_res, corrupt, phase, addr_pend, rb_pend, rd_on, rdy_q;

  assign wr_data = wr_go & addr_pend;
  assign gd_next = (addr_q == ADDR_W'(GD_A)) ? d_in : regs[GD_A];
  assign lo_word = {res_q[LSB_W-1:0], dv_res & ~corrupt & ~res_valid, st_q, {PAD_W{1'b0}}};
  assign rd_word = rb_pend ? regs[regs[CTRL_A][ADDR_W-1:0]]
                 : phase   ? lo_word : res_q[RES_W-1:LSB_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == GD_A) ? DATA_W'(GD_INIT) : '0;
    end else if (wr_data) begin
      for (int i = 0; i < NREG; i++)
        if (addr_q == ADDR_W'(i)) regs[i] <= d_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_q <= '0; st_q <= '0; dv_res <= 1'b0; gd_cnt <= '0;
      d_q <= '0; rd_on <= 1'b0; rdy_q <= 1'b1; phase <= 1'b0;
      corrupt <= 1'b0; addr_pend <= 1'b0; addr_q <= '0; rb_pend <= 1'b0;
    end else begin
      rdy_q <= ~res_valid;
      if (res_valid) begin
        res_q  <= res_data;
        st_q   <= stat_in;
        dv_res <= (gd_cnt == '0);
      end
      if (wr_data)                         gd_cnt <= gd_next;
      else if (res_valid && gd_cnt != '0)  gd_cnt <= gd_cnt - 1'b1;

      if (rd_go)      rd_on <= 1'b1;
      else if (cs_s)  rd_on <= 1'b0;
      if (rd_go)      d_q   <= rd_word;

      if (rd_go && !rb_pend) phase <= ~phase;

      if (res_valid && (phase || rd_on))           corrupt <= 1'b1;
      else if (rd_go && !rb_pend && !phase)        corrupt <= 1'b0;

      if (rd_go) rb_pend <= 1'b0;
      else if (wr_data && addr_q == ADDR_W'(CTRL_A)) rb_pend <= d_in[DATA_W-1];

      if (rd_go) addr_pend <= 1'b0;
      else if (wr_go) begin
        if (!addr_pend) begin
          addr_q    <= d_in[ADDR_W-1:0];
          addr_pend <= 1'b1;
        end else addr_pend <= 1'b0;
      end
    end

  assign d_out = d_q;
  assign d_oe  = rd_on;
  assign rdy_n = rdy_q;
endmodule

module adc_bus_port_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic          rdy_n,
  input logic          d_oe,
  input logic          cs_s,
  input logic          rw_s,
  input logic          rd_go,
  input logic          addr_pend,
  input logic [DW-1:0] gd_cnt,
  input logic          dv_res
);
  AST_RDY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !rdy_n);  // R2
  AST_RDY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(res_valid));  // R2
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !d_oe);  // R5
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_oe) |-> $past(!rw_s));  // R5
  AST_READ_DROPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !addr_pend);  // R7
  AST_DELAY_HOLDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && gd_cnt != '0) |=> !dv_res);  // R10
endmodule

bind adc_bus_port adc_bus_port_chk #(.DW(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .rdy_n(rdy_n), .d_oe(d_oe),
  .cs_s(cs_s), .rw_s(rw_s), .rd_go(rd_go), .addr_pend(addr_pend),
  .gd_cnt(gd_cnt), .dv_res(dv_res));

// File: tb/adc_bus_port_test.sv
module adc_bus_port_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rw_n = 1'b1, res_valid = 1'b0;
  logic [15:0] d_in = '0, d_out;
  logic [23:0] res_data = '0;
  logic [4:0]  stat_in = '0;
  logic        d_oe, rdy_n;
  int checks = 0, fails = 0;
  bit done = 0;

  adc_bus_port uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe), .res_valid(res_valid), .res_data(res_data),
    .stat_in(stat_in), .rdy_n(rdy_n));

  always #(CLK_P/2) clk = ~clk;

  logic [23:0] m_res = '0;
  logic [4:0]  m_st = '0;
  logic        m_dv = 0, m_cor = 0, m_ph = 0, m_ap = 0, m_rbp = 0;
  logic [1:0]  m_addr = '0;
  logic [15:0] m_regs [4] = '{default: '0};
  int          m_gd = 0;

  function automatic logic [15:0] exp_word();
    if (m_rbp)     return m_regs[m_regs[0][1:0]];
    else if (m_ph) return {m_res[7:0], m_dv & ~m_cor, m_st, 2'b00};
    else           return m_res[23:8];
  endfunction

  function automatic string read_tag();
    return m_rbp ? "R8" : (m_ph ? "R4" : "R3");
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_read(input string tag);
    logic [15:0] e;
    e = exp_word();
    @(negedge clk) rw_n = 0;
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    chk("R5 drive during read", 32'(d_oe), 32'd1);
    chk(tag, 32'(d_out), 32'(e));
    cs_n = 1; rw_n = 1;
    if (!m_rbp) begin
      if (!m_ph) m_cor = 0;
      m_ph = ~m_ph;
    end
    m_rbp = 0; m_ap = 0;
    repeat (4) @(negedge clk);
    chk("R5 release after read", 32'(d_oe), 32'd0);
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(negedge clk) begin rw_n = 1; d_in = d; end
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    chk("R5 no drive on write", 32'(d_oe), 32'd0);
    cs_n = 1;
    repeat (4) @(negedge clk);
    if (!m_ap) begin m_addr = d[1:0]; m_ap = 1; end
    else begin
      m_regs[m_addr] = d; m_ap = 0;
      if (m_addr == 0) m_rbp = d[15];
      m_gd = int'(m_regs[1]);
    end
  endtask

  task automatic load(input logic [23:0] d, input logic [4:0] s);
    @(negedge clk) begin res_valid = 1; res_data = d; stat_in = s; end
    @(negedge clk) begin
      chk("R2 ready low", 32'(rdy_n), 32'd0);
      res_valid = 0;
    end
    @(negedge clk) chk("R2 ready single cycle", 32'(rdy_n), 32'd1);
    m_res = d; m_st = s; m_dv = (m_gd == 0);
    if (m_gd > 0) m_gd--;
    if (m_ph) m_cor = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe at reset", 32'(d_oe), 32'd0);
    chk("R1 ready at reset", 32'(rdy_n), 32'd1);
    bus_read("R1 reset msb");
    bus_read("R1 reset lsb");

    load(24'hABCDEF, 5'b10110);
    bus_read("R3 upper word");
    bus_read("R4 lower word");

    bus_write(16'h0002); bus_write(16'h1234);
    bus_write(16'h0000); bus_write(16'h8002);
    bus_read("R8 readback reg2");
    bus_read("R8 no phase advance, R6 stored");

    bus_write(16'h0002);
    bus_read("R7 read between phases");
    bus_write(16'h0003); bus_write(16'h5555);
    bus_write(16'h0000); bus_write(16'h8003);
    bus_read("R7 data went to reg3");
    bus_write(16'h0000); bus_write(16'h8002);
    bus_read("R7 reg2 untouched");

    load(24'h111111, 5'b00001);
    if (m_ph) bus_read("R4 realign");
    bus_read("R9 first word");
    load(24'h2233C4, 5'b11111);
    bus_read("R9 overwritten second word");
    bus_read("R9 fresh upper");
    bus_read("R9 fresh lower valid");

    bus_write(16'h0001); bus_write(16'h0003);
    for (int k = 0; k < 4; k++) begin
      load(24'(32'h00A5A5 + k), 5'b01010);
      bus_read("R10 upper");
      bus_read(k < 3 ? "R10 held invalid" : "R10 valid again");
    end

    for (int n = 0; n < 200; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) load(24'($urandom), 5'($urandom));
      else if (op < 8) bus_read(read_tag());
      else begin
        logic [15:0] d;
        d = 16'($urandom);
        if (m_ap && m_addr == 1) d = d & 16'h0003;
        bus_write(d);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule